// File: doc/BRIEF.md
# Branch and Jump Next-PC Resolver

This execute-stage block works out where a simple 32/64-bit core fetches next. It takes one control-transfer operation per cycle. The operation is already decoded and comes with its register operands, immediate, current and sequential PCs, the saved exception PC and the status bits. For a conditional branch the block compares two operands. For jumps and exception return it selects a target. In both cases it checks that the target is aligned before committing it.

A taken transfer moves the next PC to its target only when the target is aligned. The mask used for that check depends on whether compressed instructions are enabled. A misaligned target raises an instruction-address-misaligned trap. The next PC then stays at the sequential PC, the link write is suppressed, and the faulting address is latched into a bad-address register on the following clock edge. An exception return while traps are already enabled raises an illegal-instruction trap instead. A successful exception return updates the status bits.

All paths are combinational except the bad-address register. Status bit positions are: bit 0 supervisor, bit 1 previous supervisor, bit 2 trap enable, bit 3 compressed enable.

Top module: `nextpc_resolver`

## Requirements
- R1: Operation codes 1 to 6 compare rs1_val with rs2_val as equal, not equal, signed less-than, signed greater-or-equal, unsigned less-than and unsigned greater-or-equal. If the condition holds, the target is cur_pc+imm. When wide_mode is 0, only bits 31:0 of each operand are compared: sign-extended for the signed compares and zero-extended for the others.
- R2: A condition that fails, operation 0, or any code above 14 gives next_pc = seq_pc, trap = 0 and link_we = 0.
- R3: A target counts as misaligned when bit 0 is set if status bit 3 is 1, and when bits 1:0 are nonzero if status bit 3 is 0.
- R4: A misaligned target raises trap with trap_cause 1 and gives next_pc = seq_pc. bad_addr takes the target on the next clock edge and otherwise holds. Reset clears it to 0.
- R5: Operation 7 jumps to cur_pc+imm without a link write. Operation 8 jumps to the same target and writes seq_pc into the return-address register (link_to_ra = 1).
- R6: Operation 9 jumps to rs1_val+imm and writes seq_pc into the destination register (link_to_ra = 0). The target uses the operand value as it was presented.
- R7: Operation 13 jumps to rs1_val. It writes seq_pc into the return-address register only when imm bit 5 is 1.
- R8: Operation 14 with status bit 2 set raises trap with trap_cause 2 and gives next_pc = seq_pc, with status unchanged.
- R9: Operation 14 with status bit 2 clear jumps to epc. On success status_out sets bit 2, keeps bit 0 only if bit 1 is set, and clears bit 0 otherwise.
- R10: Whenever trap is 1, link_we is 0 and status_out equals status_in.
- R11: Operations 10 and 11 are the compressed equal and not-equal branches, with target cur_pc+imm. Operation 12 is the compressed direct jump to cur_pc+imm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bad-address register |
| rst_n | input | 1 | Active-low reset |
| op | input | 4 | Decoded operation code |
| wide_mode | input | 1 | 1: full register width, 0: 32-bit compares |
| rs1_val | input | XLEN | First source operand |
| rs2_val | input | XLEN | Second source operand |
| imm | input | XLEN | Sign-extended immediate |
| cur_pc | input | XLEN | PC of this instruction |
| seq_pc | input | XLEN | Sequential next PC |
| epc | input | XLEN | Saved exception PC |
| status_in | input | 4 | Current status bits |
| next_pc | output | XLEN | Resolved next PC |
| link_we | output | 1 | Link write enable |
| link_to_ra | output | 1 | 1: return-address register, 0: destination register |
| link_data | output | XLEN | Link value |
| trap | output | 1 | Trap raised |
| trap_cause | output | 2 | 0 none, 1 misaligned target, 2 illegal exception return |
| bad_addr | output | XLEN | Last misaligned target |
| status_out | output | 4 | Updated status bits |

## Verification
The bench builds the block with XLEN = 64 and switches wide_mode during the run. This makes both the full-width and the 32-bit truncated comparisons reachable. It includes operands whose upper halves disagree while their lower halves are equal or differ in sign. Targets and the compressed-enable bit are varied so that both alignment masks show up in passing and in trapping cases.

// File: rtl/nextpc_resolver.sv
module nextpc_resolver #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      op,
  input  logic            wide_mode,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [XLEN-1:0] rs2_val,
  input  logic [XLEN-1:0] imm,
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] epc,
  input  logic [3:0]      status_in,
  output logic [XLEN-1:0] next_pc,
  output logic            link_we,
  output logic            link_to_ra,
  output logic [XLEN-1:0] link_data,
  output logic            trap,
  output logic [1:0]      trap_cause,
  output logic [XLEN-1:0] bad_addr,
  output logic [3:0]      status_out
);
  localparam logic [3:0] OP_BEQ = 4'd1, OP_BNE = 4'd2, OP_BLT = 4'd3,
    OP_BGE = 4'd4, OP_BLTU = 4'd5, OP_BGEU = 4'd6, OP_J = 4'd7,
    OP_JAL = 4'd8, OP_JALR = 4'd9, OP_CBEQ = 4'd10, OP_CBNE = 4'd11,
    OP_CJ = 4'd12, OP_CJR = 4'd13, OP_ERET = 4'd14;
  localparam int ST_S = 0, ST_PS = 1, ST_ET = 2, ST_EC = 3;

  logic [XLEN-1:0] ua, ub, sa, sb, tgt, align_mask;
  logic eq, slt, ult, xfer, lnk, ra, illegal, mis;

  generate
    if (XLEN > 32) begin : g_trunc
      assign ua = wide_mode ? rs1_val : {{(XLEN-32){1'b0}}, rs1_val[31:0]};
      assign ub = wide_mode ? rs2_val : {{(XLEN-32){1'b0}}, rs2_val[31:0]};
      assign sa = wide_mode ? rs1_val : {{(XLEN-32){rs1_val[31]}}, rs1_val[31:0]};
      assign sb = wide_mode ? rs2_val : {{(XLEN-32){rs2_val[31]}}, rs2_val[31:0]};
    end else begin : g_plain
      assign ua = rs1_val;
      assign ub = rs2_val;
      assign sa = rs1_val;
      assign sb = rs2_val;
    end
  endgenerate

  assign eq  = (ua == ub);
  assign ult = (ua < ub);
  assign slt = ($signed(sa) < $signed(sb));

  always_comb begin
    xfer    = 1'b0;
    lnk     = 1'b0;
    ra      = 1'b0;
    illegal = 1'b0;
    tgt     = cur_pc + imm;
    case (op)
      OP_BEQ, OP_CBEQ: xfer = eq;
      OP_BNE, OP_CBNE: xfer = !eq;
      OP_BLT:  xfer = slt;
      OP_BGE:  xfer = !slt;
      OP_BLTU: xfer = ult;
      OP_BGEU: xfer = !ult;
      OP_J, OP_CJ: xfer = 1'b1;
      OP_JAL: begin xfer = 1'b1; lnk = 1'b1; ra = 1'b1; end
      OP_JALR: begin xfer = 1'b1; lnk = 1'b1; tgt = rs1_val + imm; end
      OP_CJR: begin xfer = 1'b1; lnk = imm[5]; ra = 1'b1; tgt = rs1_val; end
      OP_ERET: begin
        tgt = epc;
        if (status_in[ST_ET]) illegal = 1'b1;
        else xfer = 1'b1;
      end
      default: ;
    endcase
  end

  assign align_mask = status_in[ST_EC] ? XLEN'(1) : XLEN'(3);
  assign mis        = xfer && ((tgt & align_mask) != '0);
  assign trap       = mis || illegal;
  assign trap_cause = mis ? 2'd1 : (illegal ? 2'd2 : 2'd0);
  assign next_pc    = (xfer && !mis) ? tgt : seq_pc;
  assign link_we    = lnk && !trap;
  assign link_to_ra = ra;
  assign link_data  = seq_pc;

  always_comb begin
    status_out = status_in;
    if (op == OP_ERET && !trap) begin
      status_out[ST_ET] = 1'b1;
      status_out[ST_S]  = status_in[ST_PS] ? status_in[ST_S] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   bad_addr <= '0;
    else if (mis) bad_addr <= tgt;
  end

  a_r10_trap_blocks_link: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> !link_we && status_out == status_in);
  a_r4_trap_keeps_seq: assert property (@(posedge clk) disable iff (!rst_n)
    trap |-> next_pc == seq_pc);
  a_r4_bad_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    trap_cause != 2'd1 |=> $stable(bad_addr));
  a_r3_committed_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap && next_pc != seq_pc) |->
      (status_in[ST_EC] ? !next_pc[0] : next_pc[1:0] == 2'b00));
  a_r9_eret_enables_traps: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ERET && !trap) |-> status_out[ST_ET] && next_pc == epc);
  a_r8_eret_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ERET && status_in[ST_ET]) |-> trap && trap_cause == 2'd2);
endmodule

// File: tb/nextpc_resolver_test.sv
module nextpc_resolver_test;
  localparam int XL = 64;
  localparam time TCLK = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op = 4'd0, status_in = 4'd0, status_out;
  logic wide_mode = 1'b1;
  logic [XL-1:0] rs1_val = '0, rs2_val = '0, imm = '0, cur_pc = '0, seq_pc = '0, epc = '0;
  logic [XL-1:0] next_pc, link_data, bad_addr;
  logic link_we, link_to_ra, trap;
  logic [1:0] trap_cause;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [XL-1:0] exp_bad = '0;

  always #(TCLK/2) clk = ~clk;

  nextpc_resolver #(.XLEN(XL)) uut (.*);

  typedef struct packed {
    logic [XL-1:0] npc;
    logic lwe, lra, trp;
    logic [1:0] cause;
    logic [3:0] st;
    logic mis;
    logic [XL-1:0] tg;
  } exp_t;

  function automatic logic [XL-1:0] narrow(logic [XL-1:0] v, bit wide, bit sgn);
    if (wide) return v;
    return sgn ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
  endfunction

  function automatic exp_t model(logic [3:0] o, bit wide, logic [XL-1:0] a, b, im, pc, sp, ep, logic [3:0] st);
    exp_t e;
    bit go = 0, ill = 0, lk = 0, toRa = 0;
    logic [XL-1:0] t = pc + im;
    logic signed [XL-1:0] x = narrow(a, wide, 1), y = narrow(b, wide, 1);
    logic [XL-1:0] u = narrow(a, wide, 0), w = narrow(b, wide, 0);
    case (o)
      1, 10: go = (u == w);
      2, 11: go = (u != w);
      3: go = (x < y);
      4: go = (x >= y);
      5: go = (u < w);
      6: go = (u >= w);
      7, 12: go = 1;
      8: begin go = 1; lk = 1; toRa = 1; end
      9: begin go = 1; lk = 1; t = a + im; end
      13: begin go = 1; lk = im[5]; toRa = 1; t = a; end
      14: begin t = ep; if (st[2]) ill = 1; else go = 1; end
      default: ;
    endcase
    e.tg = t;
    e.mis = go && (st[3] ? t[0] : (t[1:0] != 0));
    e.trp = e.mis || ill;
    e.cause = e.mis ? 2'd1 : ill ? 2'd2 : 2'd0;
    e.npc = (go && !e.mis) ? t : sp;
    e.lwe = lk && !e.trp;
    e.lra = toRa;
    e.st = st;
    if (o == 14 && !e.trp) begin e.st[2] = 1; if (!st[1]) e.st[0] = 0; end
    return e;
  endfunction

  function automatic string tag_of(logic [3:0] o);
    case (o)
      1, 2, 3, 4, 5, 6: return "R1";
      7, 8: return "R5";
      9: return "R6";
      10, 11, 12: return "R11";
      13: return "R7";
      14: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [XL-1:0] act, logic [XL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, logic [3:0] o, bit wide, logic [XL-1:0] a, b, im, pc, logic [3:0] st, logic [XL-1:0] ep);
    exp_t e;
    @(negedge clk);
    op = o; wide_mode = wide; rs1_val = a; rs2_val = b; imm = im;
    cur_pc = pc; seq_pc = pc + 4; epc = ep; status_in = st;
    e = model(o, wide, a, b, im, pc, pc + 4, ep, st);
    #1;
    chk(tag, "next_pc", next_pc, e.npc);
    chk(e.trp ? (e.cause == 2 ? "R8" : "R4") : tag, "trap", {62'd0, trap_cause}, {62'd0, e.cause});
    chk(e.trp ? "R10" : tag, "link_we", {63'd0, link_we}, {63'd0, e.lwe});
    if (e.lwe) begin
      chk(tag, "link_to_ra", {63'd0, link_to_ra}, {63'd0, e.lra});
      chk(tag, "link_data", link_data, pc + 4);
    end
    chk(e.trp ? "R10" : "R9", "status_out", {60'd0, status_out}, {60'd0, e.st});
    if (e.mis) exp_bad = e.tg;
    @(posedge clk); #1;
    chk("R4", "bad_addr", bad_addr, exp_bad);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1 chk("R4", "reset bad_addr", bad_addr, '0);
    rst_n = 1'b1;
    // R1 narrow equal despite upper halves differing; wide not equal
    run("R1", 1, 0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 64'h40, 64'h1000, 4'h0, 0);
    run("R1", 1, 1, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 64'h40, 64'h1000, 4'h0, 0);
    // R1 signed narrow: low half negative
    run("R1", 3, 0, 64'h0000_0000_8000_0000, 64'h1, 64'h80, 64'h2000, 4'h0, 0);
    run("R1", 3, 1, 64'h0000_0000_8000_0000, 64'h1, 64'h80, 64'h2000, 4'h0, 0);
    run("R1", 6, 0, 64'h0000_0000_8000_0000, 64'h1, 64'h80, 64'h2000, 4'h0, 0);
    // R2 not taken and idle op
    run("R2", 2, 1, 64'h5, 64'h5, 64'h3, 64'h3000, 4'h0, 0);
    run("R2", 0, 1, 64'h5, 64'h6, 64'h3, 64'h3000, 4'h0, 0);
    run("R2", 15, 1, 64'h5, 64'h6, 64'h3, 64'h3000, 4'h0, 0);
    // R3 halfword target: ok with compressed enabled, trap without
    run("R3", 7, 1, 0, 0, 64'h12, 64'h4000, 4'h8, 0);
    run("R3", 7, 1, 0, 0, 64'h12, 64'h4000, 4'h0, 0);
    // R4 byte-odd target traps even with compressed enabled
    run("R4", 12, 1, 0, 0, 64'h13, 64'h4000, 4'h8, 0);
    // R5 / R10 link and link suppression
    run("R5", 8, 1, 0, 0, 64'h100, 64'h5000, 4'h0, 0);
    run("R10", 8, 1, 0, 0, 64'h102, 64'h5000, 4'h0, 0);
    // R6 register-indirect
    run("R6", 9, 1, 64'h7000, 64'h7000, -64'sd8, 64'h6000, 4'h0, 0);
    // R7 compressed register jump, with and without link
    run("R7", 13, 1, 64'h8002, 0, 64'h20, 64'h6000, 4'h8, 0);
    run("R7", 13, 1, 64'h8002, 0, 64'h1F, 64'h6000, 4'h8, 0);
    // R8 illegal return, R9 returns
    run("R8", 14, 1, 0, 0, 0, 64'h9000, 4'h5, 64'hA000);
    run("R9", 14, 1, 0, 0, 0, 64'h9000, 4'h3, 64'hA000);
    run("R9", 14, 1, 0, 0, 0, 64'h9000, 4'h1, 64'hA004);
    run("R9", 14, 1, 0, 0, 0, 64'h9000, 4'h3, 64'hA006);
    // R11 compressed branches
    run("R11", 10, 1, 64'h9, 64'h9, 64'h6, 64'hB000, 4'h8, 0);
    run("R11", 11, 1, 64'h9, 64'h9, 64'h6, 64'hB000, 4'h8, 0);
    for (int i = 0; i < 600; i++) begin
      logic [3:0] o = 4'($urandom_range(0, 15));
      logic [XL-1:0] a = {$urandom, $urandom};
      logic [XL-1:0] b = ($urandom_range(0, 3) == 0) ? a :
                         ($urandom_range(0, 1) ? {$urandom, a[31:0]} : {$urandom, $urandom});
      logic [XL-1:0] im = XL'($signed(16'($urandom)));
      logic [XL-1:0] pc = {32'd0, $urandom} & ~64'h1;
      run(tag_of(o), o, 1'($urandom), a, b, im, pc, 4'($urandom), {$urandom, $urandom});
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule